// File: doc/BRIEF.md
# ADC Scan-Mode Conversion Sequencer

This block steps an external analog-to-digital converter through a sequence of its 24 input channels. The channels form six groups of four, and the groups form two banks of three: the lower bank holds groups 0 to 2 and the upper bank holds groups 3 to 5. Software writes one control word that holds four things: a sequence mode, a 4-bit channel/range selector, a repeat flag and an interrupt enable. It also sets a start bit in the same word. For each channel, the sequencer raises a one-cycle conversion request together with the channel number, waits for the converter's done pulse, and stores the returned sample in a 24-entry result file at that channel's index.

A one-shot sequence converts each channel in its range once, in ascending order. It then sets a completion flag and clears the start bit. A repeating scan wraps to the lowest channel of its range and keeps running until software clears the start bit. The interrupt is a level output. It stays high while both the completion flag and the interrupt enable are set.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, the control word reads 0, every result reads 0, and both `conv_req` and `irq` are low.
- R2: The control word is at address 0. Bits 3:0 are the selector, bits 5:4 the mode, bit 6 repeat, bit 7 interrupt enable, bit 8 start and bit 9 the completion flag. Result n reads at address 32+n, zero-extended; results above 23 read 0.
- R3: Mode 00 (single) converts channel `sel` exactly once and then stops, even when repeat is 1.
- R4: Mode 01 (4-channel) converts one group, ascending. Bit 3 of the selector picks the bank, and bits 1:0 pick the group within the bank, where value 3 is treated as 2. The first channel is 12*bit3 + 4*group.
- R5: Mode 10 (8-channel) converts channels 0–7 when selector bit 3 is 0, and channels 12–19 when it is 1.
- R6: Mode 11 (12-channel) converts channels 0–11 when selector bit 3 is 0, and channels 12–23 when it is 1.
- R7: When repeat is 0, the sequence stops after its highest channel's result. The completion flag sets, the start bit clears, and no further request follows.
- R8: When repeat is 1 in a scan mode, the sequence restarts at its lowest channel after the highest one, and the completion flag sets at the end of every pass. After software clears start, the outstanding conversion completes and no new request is issued.
- R9: `irq` is high exactly while the completion flag and the enable are both 1. Writing 0 to either bit removes it. Writing 1 to the flag bit leaves the flag unchanged.
- R10: While the start bit is 1, writes to the mode and selector fields are ignored and the sequence is unchanged.
- R11: Each converter sample is stored in the result entry of the channel named when it was requested.
- R12: `conv_req` is a single-cycle pulse. The next request never comes before the previous request's `conv_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address (0 control, 32+n result n) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| conv_req | output | 1 | One-cycle conversion request |
| conv_ch | output | 5 | Channel for the current conversion |
| conv_done | input | 1 | Converter completion pulse |
| conv_data | input | 10 | Converter sample, valid with `conv_done` |
| irq | output | 1 | Interrupt level |

## Verification
The start bit lands on the clock edge of its write. The first `conv_req` is visible one cycle later, and each later request comes one cycle after the `conv_done` that closes the previous conversion. The result entry, the completion flag, `irq` and the cleared start bit all change on the edge that samples the final `conv_done`, so they are readable in the following cycle. The bench samples requests and register reads on the falling edge. It matches every request against a queue of expected channels, and it polls the start bit before checking the flag, `irq` and the stored results. Checks for the absence of requests wait well past the converter latency.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int NUM_CH = 24;
  localparam int CH_W   = $clog2(NUM_CH);

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_SCAN4  = 2'b01,
    MODE_SCAN8  = 2'b10,
    MODE_SCAN12 = 2'b11
  } scan_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_WAIT = 2'd2
  } seq_state_e;

  // Bank base: 0 for the lower bank, 12 for the upper.
  function automatic logic [CH_W-1:0] bank_base(logic [3:0] sel);
    return sel[3] ? CH_W'(12) : CH_W'(0);
  endfunction

  // Group index within a bank, saturated at 2.
  function automatic logic [1:0] bank_group(logic [3:0] sel);
    return (sel[1:0] == 2'd3) ? 2'd2 : sel[1:0];
  endfunction

  function automatic logic [CH_W-1:0] range_first(scan_mode_e m, logic [3:0] sel);
    case (m)
      MODE_SINGLE: return {1'b0, sel};
      MODE_SCAN4:  return bank_base(sel) + {1'b0, bank_group(sel), 2'b00};
      default:     return bank_base(sel);
    endcase
  endfunction

  function automatic logic [CH_W-1:0] range_last(scan_mode_e m, logic [3:0] sel);
    case (m)
      MODE_SINGLE: return {1'b0, sel};
      MODE_SCAN4:  return bank_base(sel) + {1'b0, bank_group(sel), 2'b11};
      MODE_SCAN8:  return bank_base(sel) + CH_W'(7);
      default:     return bank_base(sel) + CH_W'(11);
    endcase
  endfunction
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [9:0] wdata,
  input  logic       pass_done,
  input  logic       seq_stop,
  output scan_mode_e mode,
  output logic [3:0] sel,
  output logic       rpt,
  output logic       ien,
  output logic       start,
  output logic       flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode  <= MODE_SINGLE;
      sel   <= '0;
      rpt   <= 1'b0;
      ien   <= 1'b0;
      start <= 1'b0;
      flag  <= 1'b0;
    end else begin
      if (wr_en) begin
        if (!start) begin
          mode <= scan_mode_e'(wdata[5:4]);
          sel  <= wdata[3:0];
        end
        rpt   <= wdata[6];
        ien   <= wdata[7];
        start <= wdata[8];
        flag  <= flag & wdata[9];
      end
      // Hardware events take priority over a software write in the same cycle.
      if (pass_done) flag  <= 1'b1;
      if (seq_stop)  start <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_seq_engine.sv
module adc_seq_engine
  import adc_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            rpt,
  input  scan_mode_e      mode,
  input  logic [3:0]      sel,
  input  logic            conv_done,
  output logic            conv_req,
  output logic [CH_W-1:0] conv_ch,
  output logic            store,
  output logic            pass_done,
  output logic            seq_stop
);
  seq_state_e      state;
  logic [CH_W-1:0] cur_ch, first_q, last_q;
  logic            single_q;
  logic            at_last, rpt_eff, keep_going;

  assign at_last    = (cur_ch == last_q);
  assign rpt_eff    = rpt && !single_q;
  assign store      = (state == SQ_WAIT) && conv_done;
  assign pass_done  = store && at_last;
  assign seq_stop   = pass_done && !rpt_eff;
  assign keep_going = start && (!at_last || rpt_eff);
  assign conv_req   = (state == SQ_REQ);
  assign conv_ch    = cur_ch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      cur_ch   <= '0;
      first_q  <= '0;
      last_q   <= '0;
      single_q <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: if (start) begin
          first_q  <= range_first(mode, sel);
          last_q   <= range_last(mode, sel);
          cur_ch   <= range_first(mode, sel);
          single_q <= (mode == MODE_SINGLE);
          state    <= SQ_REQ;
        end
        SQ_REQ: state <= SQ_WAIT;
        SQ_WAIT: if (conv_done) begin
          if (keep_going) begin
            cur_ch <= at_last ? first_q : cur_ch + CH_W'(1);
            state  <= SQ_REQ;
          end else begin
            state  <= SQ_IDLE;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_results.sv
module adc_seq_results #(
  parameter int NUM   = 24,
  parameter int IDX_W = 5,
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [RES_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [RES_W-1:0] rd_data
);
  logic [RES_W-1:0] mem_q [NUM];

  for (genvar i = 0; i < NUM; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)                                  mem_q[i] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(i)))     mem_q[i] <= wr_data;
    end
  end

  assign rd_data = (rd_idx < IDX_W'(NUM)) ? mem_q[rd_idx] : '0;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              conv_req,
  output logic [CH_W-1:0]   conv_ch,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  output logic              irq
);
  localparam int PAD = DATA_W - RES_W;

  scan_mode_e       ctl_mode;
  logic [3:0]       ctl_sel;
  logic             ctl_rpt, ctl_ien, ctl_start, ctl_flag;
  logic             ctrl_wr, store, pass_done, seq_stop;
  logic [RES_W-1:0] res_rd;
  logic             unused_wbits;

  assign ctrl_wr      = reg_we && (reg_addr == '0);
  assign unused_wbits = ^reg_wdata[DATA_W-1:10];

  adc_seq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr), .wdata(reg_wdata[9:0]),
    .pass_done(pass_done), .seq_stop(seq_stop),
    .mode(ctl_mode), .sel(ctl_sel), .rpt(ctl_rpt), .ien(ctl_ien),
    .start(ctl_start), .flag(ctl_flag)
  );

  adc_seq_engine u_engine (
    .clk(clk), .rst_n(rst_n), .start(ctl_start), .rpt(ctl_rpt),
    .mode(ctl_mode), .sel(ctl_sel), .conv_done(conv_done),
    .conv_req(conv_req), .conv_ch(conv_ch), .store(store),
    .pass_done(pass_done), .seq_stop(seq_stop)
  );

  adc_seq_results #(.NUM(NUM_CH), .IDX_W(CH_W), .RES_W(RES_W)) u_results (
    .clk(clk), .rst_n(rst_n), .wr_en(store), .wr_idx(conv_ch),
    .wr_data(conv_data), .rd_idx(reg_addr[CH_W-1:0]), .rd_data(res_rd)
  );

  assign irq = ctl_flag & ctl_ien;

  always_comb begin
    if (reg_addr[ADDR_W-1])
      reg_rdata = {{PAD{1'b0}}, res_rd};
    else if (reg_addr == '0)
      reg_rdata = DATA_W'({ctl_flag, ctl_start, ctl_ien, ctl_rpt, ctl_mode, ctl_sel});
    else
      reg_rdata = '0;
  end
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ctrl_wr,
  input logic [7:7] wen_bit,
  input logic       conv_req,
  input logic [4:0] conv_ch,
  input logic       irq,
  input logic       pass_done,
  input logic       seq_stop,
  input logic       ctl_start,
  input logic       ctl_ien,
  input logic       ctl_flag,
  input logic [1:0] ctl_mode,
  input logic [3:0] ctl_sel
);
  // R12: request lasts exactly one cycle
  p_req_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req);

  // R12: requested channel is a real channel
  p_ch_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> (conv_ch < 5'd24));

  // R7: completed pass raises the flag
  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done |=> ctl_flag);

  // R7: one-shot completion clears start
  p_stop_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_stop |=> !ctl_start);

  // R9: completion with enable set gives an interrupt
  p_irq_on_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_done && ctl_ien && !ctrl_wr) |=> irq);

  // R9: writing the enable low removes the interrupt
  p_irq_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wen_bit[7]) |=> !irq);

  // R10: mode and selector hold while start stays set
  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_start && $past(ctl_start)) |-> ($stable(ctl_mode) && $stable(ctl_sel)));
endmodule

bind adc_seq_ctrl adc_seq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wen_bit(reg_wdata[7]),
  .conv_req(conv_req), .conv_ch(conv_ch), .irq(irq),
  .pass_done(pass_done), .seq_stop(seq_stop), .ctl_start(ctl_start),
  .ctl_ien(ctl_ien), .ctl_flag(ctl_flag), .ctl_mode(ctl_mode), .ctl_sel(ctl_sel)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        conv_req;
  logic [4:0]  conv_ch;
  logic        conv_done = 1'b0;
  logic [9:0]  conv_data = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int req_seen = 0;
  int salt = 0;
  bit finished = 0;
  int exp_q[$];

  always #5 clk = ~clk;

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .conv_req(conv_req),
    .conv_ch(conv_ch), .conv_done(conv_done), .conv_data(conv_data), .irq(irq)
  );

  function automatic int sample_of(int ch, int s);
    return (ch * 37 + s * 11 + 3) % 1024;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Converter model: fixed latency from request to done.
  initial begin
    forever begin
      @(negedge clk);
      if (conv_req === 1'b1) begin
        automatic int ch = conv_ch;
        repeat (LAT) @(posedge clk);
        #1 conv_done = 1'b1;
        conv_data = 10'(sample_of(ch, salt));
        @(posedge clk);
        #1 conv_done = 1'b0;
      end
    end
  end

  // Monitor: every request must match the head of the expectation queue (R12, R4-R6).
  initial begin
    forever begin
      @(negedge clk);
      if (conv_req === 1'b1) begin
        req_seen++;
        if (exp_q.size() == 0) chk(1'b0, "R7 unexpected request", int'(conv_ch), -1);
        else begin
          automatic int e = exp_q.pop_front();
          chk(int'(conv_ch) == e, "R11 request channel", int'(conv_ch), e);
        end
      end
    end
  end

  function automatic logic [15:0] cw(int sel, int mode, bit rpt, bit ien, bit st, bit keepf);
    return {6'b0, keepf, st, ien, rpt, 2'(mode), 4'(sel)};
  endfunction

  task automatic wr(logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 6'd0; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk);
    reg_addr = 6'(a);
    #1 v = int'(reg_rdata);
  endtask

  task automatic wait_idle();
    int v;
    for (int i = 0; i < 2000; i++) begin
      rd(0, v);
      if (v[8] == 1'b0) return;
    end
    chk(1'b0, "R7 start never cleared", 1, 0);
  endtask

  // Driver: push the expected range, start, wait, then check flag and results.
  task automatic run_once(int mode, int sel, bit rpt, bit ien, string req);
    int lo, hi, v, g;
    g = sel % 4; if (g > 2) g = 2;
    if (mode == 0) begin lo = sel; hi = sel; end
    else begin
      lo = (sel >= 8) ? 12 : 0;
      if (mode == 1) lo = lo + g * 4;
      hi = lo + ((mode == 1) ? 3 : (mode == 2) ? 7 : 11);
    end
    salt++;
    wr(cw(sel, mode, 1'b0, 1'b0, 1'b0, 1'b0));
    for (int c = lo; c <= hi; c++) exp_q.push_back(c);
    wr(cw(sel, mode, rpt, ien, 1'b1, 1'b0));
    wait_idle();
    repeat (LAT + 6) @(negedge clk);
    chk(exp_q.size() == 0, {req, " all channels requested"}, exp_q.size(), 0);
    rd(0, v);
    chk(v[9] == 1'b1, {req, " R7 flag set"}, v[9], 1);
    chk(irq == ien, {req, " R9 irq level"}, irq, ien);
    for (int c = lo; c <= hi; c++) begin
      rd(32 + c, v);
      chk(v == sample_of(c, salt), {req, " R11 result"}, v, sample_of(c, salt));
    end
  endtask

  initial begin
    int v, base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(0, v);  chk(v == 0, "R1 control after reset", v, 0);
    rd(37, v); chk(v == 0, "R1 result after reset", v, 0);
    chk(conv_req == 1'b0 && irq == 1'b0, "R1 outputs after reset", {conv_req, irq}, 0);
    // R2 readback layout (start left 0)
    wr(16'h00F6);
    rd(0, v); chk(v == 16'h00F6, "R2 control readback", v, 16'h00F6);
    rd(63, v); chk(v == 0, "R2 out-of-range result", v, 0);
    // R3 single mode ignores repeat
    run_once(0, 13, 1'b1, 1'b1, "R3 single");
    // R9 irq clear paths
    wr(cw(13, 0, 1'b0, 1'b0, 1'b0, 1'b1)); chk(irq == 1'b0, "R9 enable cleared", irq, 0);
    rd(0, v); chk(v[9] == 1'b1, "R9 flag kept by write of 1", v[9], 1);
    wr(cw(13, 0, 1'b0, 1'b1, 1'b0, 1'b1)); chk(irq == 1'b1, "R9 enable restored", irq, 1);
    wr(cw(13, 0, 1'b0, 1'b1, 1'b0, 1'b0)); chk(irq == 1'b0, "R9 flag cleared", irq, 0);
    // R4 groups, including saturation
    run_once(1, 9, 1'b0, 1'b0, "R4 group 4");
    run_once(1, 3, 1'b0, 1'b1, "R4 group saturates");
    // R5 / R6 banks
    run_once(2, 8, 1'b0, 1'b1, "R5 upper");
    run_once(2, 0, 1'b0, 1'b0, "R5 lower");
    run_once(3, 0, 1'b0, 1'b1, "R6 lower");
    run_once(3, 12, 1'b0, 1'b0, "R6 upper");
    // R10 config writes ignored while running
    salt++;
    wr(cw(1, 1, 1'b0, 1'b0, 1'b0, 1'b0));
    for (int c = 4; c <= 7; c++) exp_q.push_back(c);
    wr(cw(1, 1, 1'b0, 1'b0, 1'b1, 1'b0));
    wr(cw(8, 3, 1'b0, 1'b0, 1'b1, 1'b0));
    rd(0, v); chk(v[5:0] == 6'h11, "R10 mode/sel held", v[5:0], 6'h11);
    wait_idle();
    repeat (LAT + 6) @(negedge clk);
    chk(exp_q.size() == 0, "R10 sequence unchanged", exp_q.size(), 0);
    // R8 repeat: nine requests, then stop
    salt++;
    wr(cw(1, 1, 1'b1, 1'b1, 1'b0, 1'b0));
    for (int k = 0; k < 9; k++) exp_q.push_back(4 + (k % 4));
    base = req_seen;
    wr(cw(1, 1, 1'b1, 1'b1, 1'b1, 1'b0));
    for (int i = 0; i < 2000 && req_seen < base + 9; i++) @(negedge clk);
    wr(cw(1, 1, 1'b1, 1'b1, 1'b0, 1'b1));
    repeat (LAT + 20) @(negedge clk);
    chk(req_seen == base + 9, "R8 no request after stop", req_seen - base, 9);
    chk(exp_q.size() == 0, "R8 wrap order", exp_q.size(), 0);
    rd(0, v); chk(v[9:8] == 2'b10, "R8 flag set, start clear", v[9:8], 2);
    rd(36, v); chk(v == sample_of(4, salt), "R8 outstanding result stored", v, sample_of(4, salt));
    chk(irq == 1'b1, "R8 irq after pass", irq, 1);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule